// File: doc/BRIEF.md
# Tree Node Packet Router

This block is one switching node of a tree-shaped network that carries short packets between processing leaves. It has one upward port (port 0) toward the parent node and `CHILDREN` downward ports (ports 1 to `CHILDREN`). Each is a full-duplex flit stream. A packet is a run of flits. Its first flit is the header, which holds a message type, a destination number and an originator number. The flits after the header are payload, and the node never looks inside them.

The node steers each packet by its destination. Leaves below one child have consecutive numbers, so every child owns one inclusive range `[low, high]` in a small table. The table is written through a plain configuration port before traffic starts. A negative destination marks a control message. Such a packet always goes up to the parent. A non-negative destination that no range covers also goes up. The lookup is combinational, and a header that reaches a free output leaves in the same cycle. Several inputs may contend for one output. A round-robin arbiter then hands that output to one whole packet at a time, and the output stays locked to that packet until its end flit has passed.

Every stream uses a valid/ready handshake. A flit moves only in a cycle where both valid and ready are high. A sender that has raised valid must keep its flit, start marker and end marker unchanged until ready is seen. The node follows the same rule on its outputs. Back-pressure on an output reaches only the input that currently owns that output. Other inputs bound for other outputs keep flowing.

Top module: `tree_node_router`

## Requirements
- R1: A flit leaves unchanged in every data bit and in its start and end markers. The header layout in a flit of `TYPE_W+2*ADDR_W` bits is: the message type in the top `TYPE_W` bits, the destination (two's complement, `ADDR_W` bits) in the next `ADDR_W` bits, and the originator in the low `ADDR_W` bits.
- R2: A packet whose destination sign bit is set goes to port 0, even when some child range would cover the same bit pattern.
- R3: A non-negative destination with `low <= dest <= high` for child c goes to port c. Both bounds are inclusive. When ranges overlap, the lowest-numbered matching child wins.
- R4: A non-negative destination outside every child range goes to port 0. After reset every range is empty, so every packet goes to port 0.
- R5: A cycle with `cfg_we` high and `cfg_sel` equal to c, for c from 1 to `CHILDREN`, loads `cfg_lo`/`cfg_hi` into the range of child c. Headers presented from the next cycle on use the new range. A write with `cfg_sel` equal to 0 or above `CHILDREN` changes nothing.
- R6: On an output with valid high and ready low, the data, start marker and end marker stay unchanged and valid stays high in the next cycle. No output is valid unless some input is valid.
- R7: Once the header of a packet has been presented on an output, that output carries only flits of that packet until the end flit has been transferred. No other packet's flits are interleaved.
- R8: When several inputs contend for one output, grants rotate. Among inputs that keep requesting, no input receives a second packet grant on that output before each of the others has received one.
- R9: A header presented to an idle output whose ready is high appears on that output in the same cycle.
- R10: While reset is asserted, with all inputs idle, every output valid and every input ready is low.
- R11: In every cycle the number of flits accepted on inputs equals the number of flits transferred on outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Range-table write strobe |
| cfg_sel | input | SEL_W | Child number to write (1..CHILDREN). Other values are ignored |
| cfg_lo | input | ADDR_W | Inclusive low bound |
| cfg_hi | input | ADDR_W | Inclusive high bound |
| in_valid | input | NP | Per-port input flit valid (bit 0 = parent) |
| in_ready | output | NP | Per-port input ready |
| in_sop | input | NP | Per-port first-flit marker |
| in_eop | input | NP | Per-port last-flit marker |
| in_data | input | NP*FLIT_W | Per-port flit, port p at bits `[p*FLIT_W +: FLIT_W]` |
| out_valid | output | NP | Per-port output flit valid |
| out_ready | input | NP | Per-port output ready |
| out_sop | output | NP | Per-port first-flit marker |
| out_eop | output | NP | Per-port last-flit marker |
| out_data | output | NP*FLIT_W | Per-port flit, same packing as `in_data` |

## Verification
The assertions assume that every sender keeps its flit and markers steady while it is stalled. They also assume that each packet opens with a start-marked header and closes with an end-marked flit, and that no range is rewritten while packets are in flight. Without these input rules, the output hold and packet-lock properties could fail through no fault of the node. The stimulus keeps to these rules in three ways. Each source is driven by one sequential task that changes its flit only after a transfer. Table writes happen only while all sources are idle. Random back-pressure touches only the ready inputs of the outputs.

// File: rtl/tnr_pkg.sv
`timescale 1ns/1ps
package tnr_pkg;
  // Output ownership state of one arbiter
  typedef enum logic {ARB_OPEN = 1'b0, ARB_HELD = 1'b1} arb_state_e;

  // Index of the upward (parent) port
  localparam int UP_PORT = 0;

  function automatic int wrap_inc(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/tnr_range_table.sv
`timescale 1ns/1ps
module tnr_range_table
  import tnr_pkg::*;
#(
  parameter int CHILDREN = 4,
  parameter int ADDR_W   = 12,
  parameter int SEL_W    = 3,
  parameter int LOOKUPS  = 5,
  localparam int NP      = CHILDREN + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [SEL_W-1:0]           cfg_sel,
  input  logic [ADDR_W-1:0]          cfg_lo,
  input  logic [ADDR_W-1:0]          cfg_hi,
  input  logic [LOOKUPS*ADDR_W-1:0]  look_addr,
  output logic [LOOKUPS*NP-1:0]      look_port
);
  // entry c holds the range of child c+1
  logic [ADDR_W-1:0] lo_q [CHILDREN];
  logic [ADDR_W-1:0] hi_q [CHILDREN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < CHILDREN; c++) begin
        lo_q[c] <= '1;
        hi_q[c] <= '0;
      end
    end else if (cfg_we) begin
      for (int c = 0; c < CHILDREN; c++) begin
        if (cfg_sel == SEL_W'(c + 1)) begin
          lo_q[c] <= cfg_lo;
          hi_q[c] <= cfg_hi;
        end
      end
    end
  end

  for (genvar l = 0; l < LOOKUPS; l++) begin : g_look
    logic [ADDR_W-1:0]   addr;
    logic [CHILDREN-1:0] hit;
    logic [NP-1:0]       oh;

    assign addr = look_addr[l*ADDR_W +: ADDR_W];

    for (genvar c = 0; c < CHILDREN; c++) begin : g_cmp
      assign hit[c] = (addr >= lo_q[c]) && (addr <= hi_q[c]);
    end

    always_comb begin
      int dst;
      dst = UP_PORT;
      if (!addr[ADDR_W-1]) begin
        for (int c = CHILDREN - 1; c >= 0; c--) begin
          if (hit[c]) dst = c + 1;
        end
      end
      oh      = '0;
      oh[dst] = 1'b1;
    end

    assign look_port[l*NP +: NP] = oh;
  end
endmodule

// File: rtl/tnr_in_track.sv
`timescale 1ns/1ps
module tnr_in_track #(
  parameter int NP = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          ready,
  input  logic          sop,
  input  logic          eop,
  input  logic [NP-1:0] route_now,
  output logic [NP-1:0] target
);
  logic          mid_q;
  logic [NP-1:0] route_q;
  logic          fire;

  assign fire = valid & ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid_q   <= 1'b0;
      route_q <= '0;
    end else if (fire) begin
      if (sop) route_q <= route_now;
      mid_q <= !eop;
    end
  end

  // payload flits follow the route latched from their header
  assign target = mid_q ? route_q : route_now;
endmodule

// File: rtl/tnr_out_arb.sv
`timescale 1ns/1ps
module tnr_out_arb
  import tnr_pkg::*;
#(
  parameter int NP     = 5,
  parameter int FLIT_W = 32,
  localparam int SW    = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NP-1:0]        req,
  input  logic [NP-1:0]        in_sop,
  input  logic [NP-1:0]        in_eop,
  input  logic [NP*FLIT_W-1:0] in_data,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic                 out_sop,
  output logic                 out_eop,
  output logic [FLIT_W-1:0]    out_data,
  output logic [NP-1:0]        grant
);
  arb_state_e    state_q;
  logic [SW-1:0] ptr_q, owner_q, pick, sel;
  logic          any_req, held, fire;

  // round-robin pick starting at ptr_q
  always_comb begin
    int idx;
    pick    = '0;
    any_req = 1'b0;
    for (int k = NP - 1; k >= 0; k--) begin
      idx = int'(ptr_q) + k;
      if (idx >= NP) idx = idx - NP;
      if (req[idx]) begin
        pick    = SW'(idx);
        any_req = 1'b1;
      end
    end
  end

  assign held      = (state_q == ARB_HELD);
  assign sel       = held ? owner_q : pick;
  assign out_valid = held ? req[owner_q] : any_req;
  assign out_data  = in_data[int'(sel)*FLIT_W +: FLIT_W];
  assign out_sop   = in_sop[sel];
  assign out_eop   = in_eop[sel];
  assign fire      = out_valid & out_ready;

  always_comb begin
    grant = '0;
    if (out_valid) grant[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ARB_OPEN;
      owner_q <= '0;
      ptr_q   <= '0;
    end else if (!held) begin
      if (any_req) begin
        ptr_q <= SW'(wrap_inc(int'(pick), NP));
        if (!(fire && out_eop)) begin
          state_q <= ARB_HELD;
          owner_q <= pick;
        end
      end
    end else if (fire && out_eop) begin
      state_q <= ARB_OPEN;
    end
  end
endmodule

// File: rtl/tree_node_router.sv
`timescale 1ns/1ps
module tree_node_router #(
  parameter int CHILDREN = 4,
  parameter int TYPE_W   = 8,
  parameter int ADDR_W   = 12,
  localparam int NP      = CHILDREN + 1,
  localparam int FLIT_W  = TYPE_W + 2 * ADDR_W,
  localparam int SEL_W   = $clog2(NP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic [ADDR_W-1:0]    cfg_lo,
  input  logic [ADDR_W-1:0]    cfg_hi,
  input  logic [NP-1:0]        in_valid,
  output logic [NP-1:0]        in_ready,
  input  logic [NP-1:0]        in_sop,
  input  logic [NP-1:0]        in_eop,
  input  logic [NP*FLIT_W-1:0] in_data,
  output logic [NP-1:0]        out_valid,
  input  logic [NP-1:0]        out_ready,
  output logic [NP-1:0]        out_sop,
  output logic [NP-1:0]        out_eop,
  output logic [NP*FLIT_W-1:0] out_data
);
  logic [NP*ADDR_W-1:0] dest_all;
  logic [NP*NP-1:0]     route_flat;   // [i*NP+o]: header on input i maps to output o
  logic [NP*NP-1:0]     target_flat;  // [i*NP+o]
  logic [NP*NP-1:0]     grant_flat;   // [o*NP+i]

  for (genvar i = 0; i < NP; i++) begin : g_dest
    assign dest_all[i*ADDR_W +: ADDR_W] = in_data[i*FLIT_W + ADDR_W +: ADDR_W];
  end

  tnr_range_table #(
    .CHILDREN(CHILDREN), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .LOOKUPS(NP)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .look_addr(dest_all), .look_port(route_flat)
  );

  for (genvar i = 0; i < NP; i++) begin : g_in
    tnr_in_track #(.NP(NP)) u_trk (
      .clk(clk), .rst_n(rst_n),
      .valid(in_valid[i]), .ready(in_ready[i]),
      .sop(in_sop[i]), .eop(in_eop[i]),
      .route_now(route_flat[i*NP +: NP]),
      .target(target_flat[i*NP +: NP])
    );
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    logic [NP-1:0] req;
    for (genvar i = 0; i < NP; i++) begin : g_req
      assign req[i] = in_valid[i] & target_flat[i*NP + o];
    end
    tnr_out_arb #(.NP(NP), .FLIT_W(FLIT_W)) u_arb (
      .clk(clk), .rst_n(rst_n),
      .req(req), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
      .out_ready(out_ready[o]),
      .out_valid(out_valid[o]), .out_sop(out_sop[o]), .out_eop(out_eop[o]),
      .out_data(out_data[o*FLIT_W +: FLIT_W]),
      .grant(grant_flat[o*NP +: NP])
    );
  end

  for (genvar i = 0; i < NP; i++) begin : g_rdy
    logic [NP-1:0] g;
    for (genvar o = 0; o < NP; o++) begin : g_or
      assign g[o] = grant_flat[o*NP + i] & out_ready[o];
    end
    assign in_ready[i] = |g;
  end
endmodule

// File: rtl/tnr_chk.sv
`timescale 1ns/1ps
module tnr_chk #(
  parameter int CHILDREN = 4,
  parameter int TYPE_W   = 8,
  parameter int ADDR_W   = 12,
  localparam int NP      = CHILDREN + 1,
  localparam int FLIT_W  = TYPE_W + 2 * ADDR_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NP-1:0]        in_valid,
  input logic [NP-1:0]        in_ready,
  input logic [NP-1:0]        out_valid,
  input logic [NP-1:0]        out_ready,
  input logic [NP-1:0]        out_sop,
  input logic [NP-1:0]        out_eop,
  input logic [NP*FLIT_W-1:0] out_data
);
  logic [NP-1:0] mid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mid_q <= '0;
    else begin
      for (int o = 0; o < NP; o++) begin
        if (out_valid[o] && out_ready[o]) mid_q[o] <= !out_eop[o];
      end
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_po
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=>
        (out_valid[o] && $stable(out_data[o*FLIT_W +: FLIT_W]) &&
         $stable(out_sop[o]) && $stable(out_eop[o])));

    assert_no_interleave_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && mid_q[o]) |-> !out_sop[o]);

    if (o != 0) begin : g_child
      assert_ctrl_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[o] && out_sop[o]) |-> !out_data[o*FLIT_W + 2*ADDR_W - 1]);
    end
  end

  assert_conserve_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_valid & in_ready) == $countones(out_valid & out_ready));

  assert_src_needed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_valid) |-> (|in_valid));
endmodule

bind tree_node_router tnr_chk #(
  .CHILDREN(CHILDREN), .TYPE_W(TYPE_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/tree_node_router_tb_top.sv
`timescale 1ns/1ps
module tree_node_router_tb_top;
  localparam int CH = 4;
  localparam int NP = CH + 1;
  localparam int AW = 12;
  localparam int TW = 8;
  localparam int FW = TW + 2 * AW;
  localparam int SW = $clog2(NP);
  localparam int RAND_PKTS = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_lo = '0, cfg_hi = '0;
  logic [NP-1:0] in_valid, in_ready, in_sop, in_eop;
  logic [NP*FW-1:0] in_data;
  logic [NP-1:0] out_valid, out_sop, out_eop;
  logic [NP-1:0] out_ready = '1;
  logic [NP*FW-1:0] out_data;

  logic          tv_valid [NP];
  logic          tv_sop   [NP];
  logic          tv_eop   [NP];
  logic [FW-1:0] tv_data  [NP];

  initial for (int p = 0; p < NP; p++) begin
    tv_valid[p] = 1'b0; tv_sop[p] = 1'b0; tv_eop[p] = 1'b0; tv_data[p] = '0;
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      in_valid[p] = tv_valid[p];
      in_sop[p]   = tv_sop[p];
      in_eop[p]   = tv_eop[p];
      in_data[p*FW +: FW] = tv_data[p];
    end
  end

  tree_node_router #(.CHILDREN(CH), .TYPE_W(TW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
    .out_eop(out_eop), .out_data(out_data)
  );

  int errs = 0, checks = 0;
  int lo_m [CH+1];
  int hi_m [CH+1];
  int exp_port [512];
  int exp_len  [512];
  int dest_of  [512];
  int got_port [512];
  bit done     [512];
  int flits_sent = 0, flits_got = 0;
  int srcs_left = 0;
  bit rand_on = 1'b0, rr_on = 1'b0, finished = 1'b0;
  int rr_log [8];
  int rr_n = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int pkt_len(input int id);
    return 1 + ((id * 7 + 3) % 4);
  endfunction

  function automatic logic [FW-1:0] pay(input int id, input int k);
    return {8'h5A, 12'(id), 12'(k)};
  endfunction

  function automatic logic [FW-1:0] hdr(input int id, input int dest);
    return {8'(id), 12'(dest), 12'(id)};
  endfunction

  // expected output port from the requirements (R2, R3, R4)
  function automatic int route(input int dest);
    if (dest < 0) return 0;
    for (int c = 1; c <= CH; c++)
      if (dest >= lo_m[c] && dest <= hi_m[c]) return c;
    return 0;
  endfunction

  task automatic cfg_write(input int sel, input int lo, input int hi);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = SW'(sel); cfg_lo = AW'(lo); cfg_hi = AW'(hi);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (sel >= 1 && sel <= CH) begin lo_m[sel] = lo; hi_m[sel] = hi; end  // R5 rule
  endtask

  task automatic send_pkt(input int p, input int id, input int dest);
    int len;
    len = pkt_len(id);
    exp_port[id] = route(dest);
    exp_len[id]  = len;
    dest_of[id]  = dest;
    done[id]     = 1'b0;
    for (int k = 0; k < len; k++) begin
      tv_valid[p] = 1'b1;
      tv_sop[p]   = (k == 0);
      tv_eop[p]   = (k == len - 1);
      tv_data[p]  = (k == 0) ? hdr(id, dest) : pay(id, k);
      do @(negedge clk); while (!in_ready[p]);
      @(posedge clk); #1;
      tv_valid[p] = 1'b0;
      flits_sent++;
    end
  endtask

  task automatic wait_done(input int id);
    while (!done[id]) @(posedge clk);
  endtask

  task automatic rand_src(input int p);
    int r, c, d;
    for (int n = 0; n < RAND_PKTS; n++) begin
      r = int'($urandom % 10);
      c = 1 + int'($urandom % CH);
      if (r < 6)       d = c * 100 + int'($urandom % 50);
      else if (r < 8)  d = -(1 + int'($urandom % 100));
      else if (r == 8) d = c * 100 + 50 + int'($urandom % 50);
      else             d = int'($urandom % 100);
      send_pkt(p, p * 64 + n, d);
      repeat (int'($urandom % 3)) @(posedge clk);
      #1;
    end
    srcs_left--;
  endtask

  task automatic send_two(input int s);
    send_pkt(s, 420 + 2 * (s - 1), -1);
    send_pkt(s, 421 + 2 * (s - 1), -1);
  endtask

  // output monitor, sampled mid-cycle
  int  cur_id [NP];
  int  cur_k  [NP];
  bit  mid    [NP];
  bit  stall  [NP];
  logic [FW+1:0] stall_v [NP];

  initial for (int o = 0; o < NP; o++) begin
    cur_id[o] = 0; cur_k[o] = 0; mid[o] = 0; stall[o] = 0; stall_v[o] = '0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int o = 0; o < NP; o++) begin
        logic [FW-1:0] d;
        int id;
        string tag;
        d = out_data[o*FW +: FW];
        if (stall[o])
          chk(out_valid[o] && ({out_sop[o], out_eop[o], d} == stall_v[o]),
              "R6 hold", int'(out_valid[o]), 1);
        stall[o]   = out_valid[o] && !out_ready[o];
        stall_v[o] = {out_sop[o], out_eop[o], d};
        if (out_valid[o] && out_ready[o]) begin
          flits_got++;
          if (out_sop[o]) begin
            id = int'(d[11:0]);
            chk(!mid[o], "R7 sop inside packet", id, cur_id[o]);
            if (dest_of[id] < 0)     tag = "R2 route";
            else if (exp_port[id] == 0) tag = "R4 route";
            else                     tag = "R3 route";
            chk(o == exp_port[id], tag, o, exp_port[id]);
            chk(d == hdr(id, dest_of[id]), "R1 header", int'(d[FW-1:AW]),
                int'(hdr(id, dest_of[id]) >> AW));
            got_port[id] = o;
            cur_id[o] = id; cur_k[o] = 1;
            if (rr_on && o == 0 && id >= 420 && id < 426 && rr_n < 8) begin
              rr_log[rr_n] = (id - 420) / 2 + 1;
              rr_n++;
            end
            if (out_eop[o]) begin
              chk(exp_len[id] == 1, "R7 length", 1, exp_len[id]);
              mid[o] = 0; done[id] = 1'b1;
            end else mid[o] = 1;
          end else begin
            id = cur_id[o];
            chk(mid[o], "R7 orphan flit", 0, 1);
            chk(d == pay(id, cur_k[o]), "R1 payload", int'(d[11:0]), cur_k[o]);
            chk(out_eop[o] == (cur_k[o] == exp_len[id] - 1), "R7 end marker",
                int'(out_eop[o]), int'(cur_k[o] == exp_len[id] - 1));
            cur_k[o]++;
            if (out_eop[o]) begin mid[o] = 0; done[id] = 1'b1; end
          end
        end
      end
    end
  end

  // random back-pressure on outputs
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rand_on)
        for (int o = 0; o < NP; o++) out_ready[o] = ($urandom % 4) != 0;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int missing;
    void'($urandom(32'd20240611));
    for (int c = 0; c <= CH; c++) begin lo_m[c] = 4095; hi_m[c] = 0; end
    for (int i = 0; i < 512; i++) begin
      exp_port[i] = 0; exp_len[i] = 1; dest_of[i] = 0; got_port[i] = -1; done[i] = 0;
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_valid == '0, "R10 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == '0, "R10 in_ready in reset", int'(in_ready), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R4: empty table after reset sends everything up
    send_pkt(1, 400, 150); wait_done(400);
    chk(got_port[400] == 0, "R4 empty table", got_port[400], 0);

    // R5: writes with an invalid selector are ignored
    cfg_write(0, 0, 4000);
    cfg_write(CH + 1, 0, 4000);
    send_pkt(2, 401, 150); wait_done(401);
    chk(got_port[401] == 0, "R5 ignored write", got_port[401], 0);

    // R3: overlap, inclusive bounds, lowest child wins
    cfg_write(1, 10, 20);
    cfg_write(2, 15, 30);
    send_pkt(0, 402, 17); wait_done(402);
    chk(got_port[402] == 1, "R3 overlap", got_port[402], 1);
    send_pkt(0, 403, 30); wait_done(403);
    chk(got_port[403] == 2, "R3 high bound", got_port[403], 2);
    send_pkt(0, 404, 10); wait_done(404);
    chk(got_port[404] == 1, "R3 low bound", got_port[404], 1);
    send_pkt(0, 405, 31); wait_done(405);
    chk(got_port[405] == 0, "R4 above range", got_port[405], 0);

    // R2: negative destination goes up even if a range covers its bit pattern
    cfg_write(3, 2048, 4095);
    send_pkt(4, 406, -5); wait_done(406);
    chk(got_port[406] == 0, "R2 negative", got_port[406], 0);
    send_pkt(0, 407, 2047); wait_done(407);
    chk(got_port[407] == 0, "R4 positive gap", got_port[407], 0);

    // R9: same-cycle pass-through to an idle output
    exp_port[410] = route(17); exp_len[410] = 1; dest_of[410] = 17; done[410] = 0;
    tv_valid[4] = 1'b1; tv_sop[4] = 1'b1; tv_eop[4] = 1'b1; tv_data[4] = hdr(410, 17);
    @(negedge clk);
    chk(out_valid[1] && out_data[FW +: FW] == hdr(410, 17), "R9 same cycle",
        int'(out_valid[1]), 1);
    @(posedge clk); #1;
    tv_valid[4] = 1'b0;
    flits_sent++;
    wait_done(410);

    // R8: three inputs contend for the parent port
    out_ready[0] = 1'b0;
    rr_on = 1'b1;
    fork
      send_two(1);
      send_two(2);
      send_two(3);
      begin repeat (4) @(posedge clk); #1; out_ready[0] = 1'b1; end
    join
    for (int i = 420; i < 426; i++) wait_done(i);
    rr_on = 1'b0;
    chk(rr_n == 6, "R8 grant count", rr_n, 6);
    chk(rr_log[0] != rr_log[1] && rr_log[1] != rr_log[2] && rr_log[0] != rr_log[2],
        "R8 first round", rr_log[0] * 100 + rr_log[1] * 10 + rr_log[2], 123);
    chk(rr_log[3] != rr_log[4] && rr_log[4] != rr_log[5] && rr_log[3] != rr_log[5],
        "R8 second round", rr_log[3] * 100 + rr_log[4] * 10 + rr_log[5], 123);

    // random traffic with back-pressure
    for (int c = 1; c <= CH; c++) cfg_write(c, c * 100, c * 100 + 49);
    rand_on = 1'b1;
    srcs_left = NP;
    for (int p = 0; p < NP; p++) begin
      automatic int pp = p;
      fork rand_src(pp); join_none
    end
    while (srcs_left != 0) @(posedge clk);
    rand_on = 1'b0;
    #1 out_ready = '1;
    repeat (30) @(posedge clk);

    missing = 0;
    for (int p = 0; p < NP; p++)
      for (int n = 0; n < RAND_PKTS; n++)
        if (!done[p * 64 + n]) missing++;
    chk(missing == 0, "R11 packets delivered", missing, 0);
    chk(flits_got == flits_sent, "R11 flit count", flits_got, flits_sent);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule